// File: doc/BRIEF.md
# Strand Pause Counter

This block holds one hardware thread idle for a requested number of cycles. A write on the request port carries a 64-bit cycle count. The block keeps only the coarse part of that count, which is the value divided by eight. It then counts that value down by one every eight clock cycles, and raises `stall` for as long as any count remains. A requested count below eight still produces a single-cycle stall. Busy-wait and backoff loops use it to give the core to other threads for roughly the requested time, with no software loop.

A disrupting trap input ends the pause at once and clears all internal state. A new request during an active pause replaces the remaining count and restarts the divide-by-eight prescaler. The stalled pipeline and the logic that raises traps lie outside this block.

Top module: `strand_pause_unit`

## Requirements
- R1: After reset, `stall` is low and stays low until a request is accepted.
- R2: A request with value v of 8 or more makes `stall` high for exactly 8*(v>>3) consecutive cycles. The low three bits of v have no effect on this length.
- R3: A request with value v in 0..7, zero included, makes `stall` high for exactly one cycle.
- R4: `stall` goes high in the first cycle after the edge that accepts the request.
- R5: When `trap_in` is high at an edge during a stall, `stall` is low from the next cycle on and does not come back without a new request.
- R6: A request presented in the same cycle as `trap_in` is discarded, and `stall` stays low.
- R7: A request during an active stall replaces the remaining count. From that request, `stall` stays high for exactly the length that R2/R3 give for the new value.
- R8: `trap_in` while idle has no effect, and a later request behaves as in R2.
- R9: The full 64-bit width is honoured. A request of all ones keeps `stall` high for far longer than any small request, until a trap ends it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_wr | input | 1 | Request strobe, one cycle per request |
| pause_data | input | 64 | Requested pause length in cycles |
| trap_in | input | 1 | Disrupting trap, cancels any pause |
| stall | output | 1 | High while the thread must stay idle |

## Verification
Every result appears one register stage after its cause. The edge that accepts a request makes `stall` visible in the cycle that follows (R4), and a trap at an edge drops `stall` in the cycle that follows (R5). The bench drives inputs on the falling edge and releases them one falling edge later, so its first sample of `stall` already shows the effect of that single rising edge. It then counts the high samples, one per falling edge, until `stall` drops, and compares the total with the length it computes as 8*(v>>3), or 1 for small values. Because the counting starts at that first falling edge, an early or late rise or fall changes the total and is reported.

// File: rtl/pause_pkg.sv
package pause_pkg;
  // Default request width and prescaler width (granularity = 2**GRAN_LOG2)
  localparam int unsigned PAUSE_DATA_W   = 64;
  localparam int unsigned PAUSE_GRAN_LOG2 = 3;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_LOAD   = 2'd1,
    EV_CANCEL = 2'd2
  } pause_event_e;
endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
  parameter int unsigned GRAN_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam logic [GRAN_LOG2-1:0] LAST = {GRAN_LOG2{1'b1}};

  logic [GRAN_LOG2-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      phase_q <= '0;
    else if (clr)    phase_q <= '0;
    else if (run)    phase_q <= phase_q + 1'b1;
  end

  assign tick = run && (phase_q == LAST);

  // R7
  prescale_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase_q == '0));

  // R5
  prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(phase_q));
endmodule

// File: rtl/pause_tick_counter.sv
module pause_tick_counter #(
  parameter int unsigned CNT_W = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cancel,
  input  logic             tick,
  output logic             run,
  output logic             stall
);
  logic [CNT_W-1:0] cnt_q;
  logic             stall_q;
  logic             cnt_zero;
  logic             last_tick;

  assign cnt_zero  = (cnt_q == '0);
  assign last_tick = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stall_q <= 1'b0;
    end else if (cancel) begin
      cnt_q   <= '0;
      stall_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      stall_q <= 1'b1;
    end else if (stall_q) begin
      if (cnt_zero) begin
        stall_q <= 1'b0;
      end else if (tick) begin
        cnt_q <= cnt_q - 1'b1;
        if (last_tick) stall_q <= 1'b0;
      end
    end
  end

  assign run   = stall_q && !cnt_zero;
  assign stall = stall_q;

  // R4
  stall_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_q) |-> $past(load));

  // R5
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!stall_q && cnt_zero));

  // R7
  load_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cancel) |=> (stall_q && cnt_q == $past(load_val)));

  // R2
  tick_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !cancel) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R1
  idle_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_q |-> cnt_zero);

  // R3
  short_pause_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && cnt_zero && !load) |=> !stall_q);
endmodule

// File: rtl/strand_pause_unit.sv
module strand_pause_unit
  import pause_pkg::*;
#(
  parameter int unsigned DATA_W    = PAUSE_DATA_W,
  parameter int unsigned GRAN_LOG2 = PAUSE_GRAN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pause_wr,
  input  logic [DATA_W-1:0] pause_data,
  input  logic              trap_in,
  output logic              stall
);
  localparam int unsigned CNT_W = DATA_W - GRAN_LOG2;

  // Coarse tick count kept for a requested cycle count
  function automatic logic [CNT_W-1:0] coarse_ticks(input logic [DATA_W-1:0] cycles);
    logic [DATA_W-1:0] shifted;
    shifted = cycles >> GRAN_LOG2;
    return shifted[CNT_W-1:0];
  endfunction

  pause_event_e ev;
  logic         wr_go;
  logic         tick;
  logic         run;
  logic         stall_int;

  always_comb begin
    if (trap_in)       ev = EV_CANCEL;
    else if (pause_wr) ev = EV_LOAD;
    else               ev = EV_NONE;
  end

  assign wr_go = (ev == EV_LOAD);

  pause_prescaler #(.GRAN_LOG2(GRAN_LOG2)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wr_go || trap_in),
    .run   (run),
    .tick  (tick)
  );

  pause_tick_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_go),
    .load_val (coarse_ticks(pause_data)),
    .cancel   (trap_in),
    .tick     (tick),
    .run      (run),
    .stall    (stall_int)
  );

  assign stall = stall_int;

  // R6
  trap_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_in && pause_wr) |=> !stall);

  // R4
  write_starts_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_wr && !trap_in) |=> stall);

  // R5
  tick_only_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> stall);
endmodule

// File: tb/strand_pause_unit_tb.sv
module strand_pause_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pause_wr = 1'b0;
  logic [63:0] pause_data = '0;
  logic        trap_in = 1'b0;
  logic        stall;

  int checks = 0;
  int errors = 0;
  longint unsigned cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strand_pause_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pause_wr(pause_wr),
    .pause_data(pause_data), .trap_in(trap_in), .stall(stall)
  );

  function automatic longint unsigned expect_len(input logic [63:0] v);
    longint unsigned q;
    q = v / 64'd8;
    return (q == 0) ? 1 : q * 8;
  endfunction

  task automatic check_eq(input string req, input longint unsigned act,
                          input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive request at a falling edge, release at the next one
  task automatic send(input logic [63:0] v, input logic with_trap);
    @(negedge clk);
    pause_wr = 1'b1; pause_data = v; trap_in = with_trap;
    @(negedge clk);
    pause_wr = 1'b0; trap_in = 1'b0;
  endtask

  task automatic pulse_trap();
    @(negedge clk);
    trap_in = 1'b1;
    @(negedge clk);
    trap_in = 1'b0;
  endtask

  // Count high samples of stall, one per falling edge
  task automatic measure(output longint unsigned n, input longint unsigned cap);
    n = 0;
    while (stall && n < cap) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle_span(input string req, input int span);
    int highs;
    highs = 0;
    for (int i = 0; i < span; i++) begin
      if (stall) highs++;
      @(negedge clk);
    end
    check_eq(req, highs, 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    longint unsigned n;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    check_eq("R1 stall in reset", stall, 0);
    rst_n = 1'b1;
    idle_span("R1 idle after reset", 10);

    // R2 R3 R4: sweep of request values
    for (int v = 0; v < 96; v++) begin
      send(64'(v), 1'b0);
      check_eq("R4 stall in first cycle", stall, 1);
      measure(n, 2000);
      if (v < 8) check_eq("R3 short length", n, 1);
      else       check_eq("R2 length", n, expect_len(64'(v)));
      repeat (2) @(negedge clk);
    end
    send(64'd1003, 1'b0);
    measure(n, 5000);
    check_eq("R2 length 1003", n, expect_len(64'd1003));

    // R5: trap in the middle of a pause
    send(64'd400, 1'b0);
    repeat (10) @(negedge clk);
    check_eq("R5 stalled before trap", stall, 1);
    pulse_trap();
    check_eq("R5 stall after trap", stall, 0);
    idle_span("R5 no resume", 500);

    // R6: trap together with a request
    send(64'd200, 1'b1);
    check_eq("R6 write with trap", stall, 0);
    idle_span("R6 stays idle", 250);

    // R7: reload during an active pause
    send(64'd80, 1'b0);
    repeat (13) @(negedge clk);
    send(64'd24, 1'b0);
    measure(n, 2000);
    check_eq("R7 reload length", n, 24);
    send(64'd160, 1'b0);
    repeat (5) @(negedge clk);
    send(64'd3, 1'b0);
    measure(n, 2000);
    check_eq("R7 reload to short", n, 1);

    // R8: trap while idle is harmless
    pulse_trap();
    check_eq("R8 trap idle", stall, 0);
    send(64'd16, 1'b0);
    measure(n, 2000);
    check_eq("R8 length after idle trap", n, 16);

    // R9: full-width request
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    repeat (3000) @(negedge clk);
    check_eq("R9 wide still stalled", stall, 1);
    pulse_trap();
    check_eq("R9 trap ends wide", stall, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule